// File: doc/BRIEF.md
# Segmented Logarithm Approximation Unit

This unit returns an approximate natural logarithm for one positive unsigned fixed-point operand per conversion. A conversion runs in two phases. The first phase is a four-step binary search over power-of-ten thresholds, and it settles on one of sixteen coefficient segments. Each segment covers a band of input magnitudes that widens by decades. The second phase evaluates a degree-four polynomial from that segment's five coefficients. It uses one multiplier and one adder, one term per clock.

An upstream stage offers operands on a valid/ready pair. The unit takes one operand only while it is idle and returns a signed fixed-point result with a one-cycle strobe. Software fills the 16×5 coefficient bank through a write port before conversions start. A zero operand has no logarithm. It yields the most negative output code and raises a flag that stays set until reset.

Top module: `lnx_approx_unit`

## Requirements
- R1: `in_ready` is high exactly when the unit is idle. An operand is taken on a clock edge where `in_valid` and `in_ready` are both high. From that edge until the result strobe, `in_ready` stays low, and `in_valid` or `in_data` have no effect.
- R2: The search starts each conversion with exponent −16, segment index 0 and both increments at 8. It makes exactly four steps and halves both increments after every step (8, 4, 2, 1). The final index selects the coefficient segment.
- R3: The threshold for exponent −k is floor(2^IN_FRAC / 10^k) in raw input units, computed for k = 0..31. In each step, an operand strictly below the threshold lowers the exponent by the exponent increment. Any other operand (including one equal to the threshold) raises the exponent and adds the index increment to the segment index.
- R4: With operand x (IN_FRAC fractional bits) and segment coefficients c0..c4 (signed, OUT_W bits, OUT_FRAC fractional bits), the accumulator starts at 0. Then, for i = 4 down to 0: acc = floor(acc·x / 2^IN_FRAC) + c_i. The result equals the sum of c_i·x^i up to truncation.
- R5: After every accumulation step the accumulator saturates to the signed OUT_W range: 0x7FFFFFFF above, 0x80000000 below, for the default OUT_W of 32.
- R6: `out_valid` rises exactly 10 clock edges after the accepting edge (4 search, 5 accumulation, 1 output). It stays high for one cycle, with `out_data` valid in that cycle.
- R7: A zero operand produces `out_data` equal to the most negative code (only the sign bit set).
- R8: `range_flag` goes high in the same cycle as the result strobe of a zero-operand conversion. It stays high through all later conversions until reset, and nonzero operands never set it.
- R9: When `cw_en` is high, a clock edge writes `cw_data` into coefficient `cw_term` of segment `cw_seg`, and later conversions use the new value. Term codes 5, 6 and 7 write nothing.
- R10: After reset `in_ready` is 1, `out_valid` is 0, `range_flag` is 0, `out_data` is 0, and all coefficients are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit idle, operand will be taken |
| in_data | input | IN_W | Unsigned operand, IN_FRAC fractional bits |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | OUT_W | Signed logarithm, OUT_FRAC fractional bits |
| range_flag | output | 1 | Sticky: a zero operand was converted |
| cw_en | input | 1 | Coefficient write enable |
| cw_seg | input | 4 | Segment to write |
| cw_term | input | 3 | Term number 0..4 to write; 5..7 ignored |
| cw_data | input | OUT_W | Signed coefficient value |

## Verification
A wrong search state has no port of its own. It shows up as a result computed from the wrong segment, so every segment is loaded with distinct coefficients and the error is visible in the first strobe of the affected conversion. Operands equal to a threshold and one code below it separate the strict comparison from a non-strict one within the same conversion. A step counter or term counter that is off by one moves the strobe away from its fixed 10-edge latency, and the strobe cycle is measured for every result. A flag that is not sticky, or a bad saturation limit, shows in the first later conversion after a zero operand or a large operand.

// File: rtl/lnx_pkg.sv
package lnx_pkg;

   // search geometry: four halving steps pick one of sixteen segments
   localparam int unsigned LNX_STEPS  = 4;
   localparam int unsigned LNX_SEGS   = 1 << LNX_STEPS;
   localparam int unsigned LNX_SEG_W  = LNX_STEPS;
   localparam int unsigned LNX_TERMS  = 5;
   localparam int unsigned LNX_TERM_W = $clog2(LNX_TERMS);
   // decade thresholds 10^0 .. 10^-(2*SEGS-1)
   localparam int unsigned LNX_THR_N  = 2 * LNX_SEGS;
   localparam int unsigned LNX_THR_W  = $clog2(LNX_THR_N);
   localparam int unsigned LNX_EXP_W  = LNX_THR_W + 2;
   localparam int          LNX_EXP_START = -int'(LNX_SEGS);
   localparam int unsigned LNX_LATENCY   = LNX_STEPS + LNX_TERMS + 1;

   typedef enum logic [1:0] {
      LNX_IDLE,
      LNX_SRCH,
      LNX_EVAL,
      LNX_FIN
   } lnx_state_e;

   // floor(2^frac / 10^k), exact because floor(floor(a/b)/c) = floor(a/(b*c))
   function automatic logic [127:0] lnx_decade_thr(input int unsigned k,
                                                   input int unsigned frac);
      logic [127:0] v;
      v = 128'd1 << frac;
      for (int unsigned i = 0; i < k; i++) v = v / 128'd10;
      return v;
   endfunction

endpackage

// File: rtl/lnx_decade_search.sv
module lnx_decade_search
   import lnx_pkg::*;
#(
   parameter int unsigned IN_W    = 40,
   parameter int unsigned IN_FRAC = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 init,
   input  logic                 step,
   input  logic [IN_W-1:0]      x,
   output logic [LNX_SEG_W-1:0] seg_idx
);

   logic [IN_W-1:0]             thr_tab [LNX_THR_N];
   logic signed [LNX_EXP_W-1:0] expo_q;
   logic [LNX_SEG_W-1:0]        einc_q;
   logic [LNX_SEG_W-1:0]        iinc_q;
   logic [LNX_SEG_W-1:0]        idx_q;
   logic [LNX_THR_W-1:0]        tidx;
   logic signed [LNX_EXP_W-1:0] expo_neg;
   logic signed [LNX_EXP_W-1:0] einc_s;
   logic                        below;

   for (genvar k = 0; k < int'(LNX_THR_N); k++) begin : g_thr
      localparam logic [127:0] THR_WIDE = lnx_decade_thr(k, IN_FRAC);
      assign thr_tab[k] = THR_WIDE[IN_W-1:0];
   end

   assign expo_neg = -expo_q;
   assign tidx     = LNX_THR_W'(expo_neg);
   assign below    = (x < thr_tab[tidx]);
   assign einc_s   = $signed(LNX_EXP_W'(einc_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         expo_q <= '0;
         einc_q <= '0;
         iinc_q <= '0;
         idx_q  <= '0;
      end else if (init) begin
         expo_q <= LNX_EXP_W'(LNX_EXP_START);
         einc_q <= LNX_SEG_W'(LNX_SEGS / 2);
         iinc_q <= LNX_SEG_W'(LNX_SEGS / 2);
         idx_q  <= '0;
      end else if (step) begin
         if (below) begin
            expo_q <= expo_q - einc_s;
         end else begin
            expo_q <= expo_q + einc_s;
            idx_q  <= idx_q + iinc_q;
         end
         einc_q <= einc_q >> 1;
         iinc_q <= iinc_q >> 1;
      end
   end

   assign seg_idx = idx_q;

endmodule

// File: rtl/lnx_coef_bank.sv
module lnx_coef_bank
   import lnx_pkg::*;
#(
   parameter int unsigned CW = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [LNX_SEG_W-1:0]  wr_seg,
   input  logic [LNX_TERM_W-1:0] wr_term,
   input  logic [CW-1:0]         wr_data,
   input  logic [LNX_SEG_W-1:0]  rd_seg,
   input  logic [LNX_TERM_W-1:0] rd_term,
   output logic [CW-1:0]         rd_data
);

   localparam int unsigned ENTRIES = LNX_SEGS * LNX_TERMS;
   localparam int unsigned FLAT_W  = $clog2(ENTRIES) + 1;

   logic [CW-1:0]     flat [ENTRIES];
   logic [FLAT_W-1:0] ridx;

   for (genvar s = 0; s < int'(LNX_SEGS); s++) begin : g_seg
      for (genvar t = 0; t < int'(LNX_TERMS); t++) begin : g_term
         logic [CW-1:0] cell_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cell_q <= '0;
            else if (wr_en && wr_seg == LNX_SEG_W'(s) && wr_term == LNX_TERM_W'(t))
               cell_q <= wr_data;
         end
         assign flat[s*LNX_TERMS + t] = cell_q;
      end
   end

   assign ridx    = FLAT_W'(rd_seg) * FLAT_W'(LNX_TERMS) + FLAT_W'(rd_term);
   assign rd_data = (rd_term < LNX_TERM_W'(LNX_TERMS)) ? flat[ridx] : '0;

endmodule

// File: rtl/lnx_horner_mac.sv
module lnx_horner_mac #(
   parameter int unsigned IN_W       = 40,
   parameter int unsigned IN_FRAC    = 32,
   parameter int unsigned AW         = 32,
   parameter int unsigned ROUND_PROD = 0
) (
   input  logic signed [AW-1:0] acc_in,
   input  logic [IN_W-1:0]      x,
   input  logic signed [AW-1:0] coef,
   output logic signed [AW-1:0] acc_out
);

   localparam int unsigned PW = AW + IN_W + 1;
   localparam logic signed [PW:0] MAXV = {{(PW + 2 - AW){1'b0}}, {(AW - 1){1'b1}}};
   localparam logic signed [PW:0] MINV = ~MAXV;

   logic signed [PW-1:0] a_ext;
   logic signed [PW-1:0] x_ext;
   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] prod_adj;
   logic signed [PW-1:0] shf;
   logic signed [PW:0]   sum;

   assign a_ext = PW'(acc_in);
   assign x_ext = PW'($signed({1'b0, x}));
   assign prod  = a_ext * x_ext;

   if (ROUND_PROD != 0) begin : g_round
      assign prod_adj = prod + $signed(PW'(1) << (IN_FRAC - 1));
   end else begin : g_trunc
      assign prod_adj = prod;
   end

   assign shf = prod_adj >>> IN_FRAC;
   assign sum = (PW+1)'(shf) + (PW+1)'(coef);

   always_comb begin
      if (sum > MAXV)
         acc_out = MAXV[AW-1:0];
      else if (sum < MINV)
         acc_out = MINV[AW-1:0];
      else
         acc_out = sum[AW-1:0];
   end

endmodule

// File: rtl/lnx_approx_unit.sv
module lnx_approx_unit
   import lnx_pkg::*;
#(
   parameter int unsigned IN_W       = 40,
   parameter int unsigned IN_FRAC    = 32,
   parameter int unsigned OUT_W      = 32,
   parameter int unsigned OUT_FRAC   = 16,
   parameter int unsigned ROUND_PROD = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [IN_W-1:0]       in_data,
   output logic                  out_valid,
   output logic [OUT_W-1:0]      out_data,
   output logic                  range_flag,
   input  logic                  cw_en,
   input  logic [LNX_SEG_W-1:0]  cw_seg,
   input  logic [LNX_TERM_W-1:0] cw_term,
   input  logic [OUT_W-1:0]      cw_data
);

   localparam int unsigned STEP_W = $clog2(LNX_STEPS);
   localparam logic [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W - 1){1'b0}}};

   // elaboration-time parameter checks
   if (IN_FRAC < 1 || IN_FRAC >= IN_W) begin : g_bad_frac
      $error("IN_FRAC must lie in 1..IN_W-1");
   end
   if (IN_FRAC > 120) begin : g_bad_wide
      $error("IN_FRAC above 120 exceeds the threshold arithmetic");
   end
   if (OUT_W < 8 || OUT_FRAC >= OUT_W) begin : g_bad_out
      $error("OUT_W must be at least 8 and exceed OUT_FRAC");
   end

   lnx_state_e                state_q;
   logic [STEP_W-1:0]         step_q;
   logic [LNX_TERM_W-1:0]     term_q;
   logic [IN_W-1:0]           x_q;
   logic signed [OUT_W-1:0]   acc_q;
   logic signed [OUT_W-1:0]   acc_nxt;
   logic [OUT_W-1:0]          coef_rd;
   logic [LNX_SEG_W-1:0]      seg_idx;
   logic                      accept;
   logic                      srch_step;

   assign in_ready  = (state_q == LNX_IDLE);
   assign accept    = in_valid && in_ready;
   assign srch_step = (state_q == LNX_SRCH);

   lnx_decade_search #(
      .IN_W    (IN_W),
      .IN_FRAC (IN_FRAC)
   ) i_search (
      .clk     (clk),
      .rst_n   (rst_n),
      .init    (accept),
      .step    (srch_step),
      .x       (x_q),
      .seg_idx (seg_idx)
   );

   lnx_coef_bank #(
      .CW (OUT_W)
   ) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cw_en),
      .wr_seg  (cw_seg),
      .wr_term (cw_term),
      .wr_data (cw_data),
      .rd_seg  (seg_idx),
      .rd_term (term_q),
      .rd_data (coef_rd)
   );

   lnx_horner_mac #(
      .IN_W       (IN_W),
      .IN_FRAC    (IN_FRAC),
      .AW         (OUT_W),
      .ROUND_PROD (ROUND_PROD)
   ) i_mac (
      .acc_in  (acc_q),
      .x       (x_q),
      .coef    ($signed(coef_rd)),
      .acc_out (acc_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= LNX_IDLE;
         step_q     <= '0;
         term_q     <= '0;
         x_q        <= '0;
         acc_q      <= '0;
         out_valid  <= 1'b0;
         out_data   <= '0;
         range_flag <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         unique case (state_q)
            LNX_IDLE: begin
               if (accept) begin
                  x_q     <= in_data;
                  acc_q   <= '0;
                  step_q  <= '0;
                  state_q <= LNX_SRCH;
               end
            end
            LNX_SRCH: begin
               if (step_q == STEP_W'(LNX_STEPS - 1)) begin
                  term_q  <= LNX_TERM_W'(LNX_TERMS - 1);
                  acc_q   <= '0;
                  state_q <= LNX_EVAL;
               end else begin
                  step_q <= step_q + 1'b1;
               end
            end
            LNX_EVAL: begin
               acc_q <= acc_nxt;
               if (term_q == '0)
                  state_q <= LNX_FIN;
               else
                  term_q <= term_q - 1'b1;
            end
            LNX_FIN: begin
               out_valid <= 1'b1;
               if (x_q == '0) begin
                  out_data   <= MIN_CODE;
                  range_flag <= 1'b1;
               end else begin
                  out_data <= acc_q;
               end
               state_q <= LNX_IDLE;
            end
            default: state_q <= LNX_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/lnx_approx_chk.sv
module lnx_approx_chk
   import lnx_pkg::*;
#(
   parameter int unsigned IN_W  = 40,
   parameter int unsigned OUT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic [IN_W-1:0]  in_data,
   input logic             out_valid,
   input logic [OUT_W-1:0] out_data,
   input logic             range_flag
);

   localparam logic [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W - 1){1'b0}}};

   logic       armed_q;
   logic [4:0] cnt_q;
   logic       zero_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
         zero_q  <= 1'b0;
      end else if (in_valid && in_ready) begin
         armed_q <= 1'b1;
         cnt_q   <= '0;
         zero_q  <= (in_data == '0);
      end else if (armed_q) begin
         if (out_valid)
            armed_q <= 1'b0;
         else if (cnt_q != 5'h1f)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready) else $error("ready stayed high"); // R1

   AST_READY_AT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> in_ready) else $error("busy during result"); // R1

   AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (armed_q && cnt_q == 5'(LNX_LATENCY))) else $error("latency"); // R6

   AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid) else $error("strobe too long"); // R6

   AST_ZERO_MIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && zero_q) |-> (out_data == MIN_CODE)) else $error("zero code"); // R7

   AST_ZERO_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && zero_q) |-> range_flag) else $error("flag not set"); // R8

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      range_flag |=> range_flag) else $error("flag cleared"); // R8

endmodule

bind lnx_approx_unit lnx_approx_chk #(
   .IN_W  (IN_W),
   .OUT_W (OUT_W)
) i_lnx_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .in_data    (in_data),
   .out_valid  (out_valid),
   .out_data   (out_data),
   .range_flag (range_flag)
);

// File: tb/test_lnx_approx_unit.sv
`timescale 1ns/1ps
module test_lnx_approx_unit;

   localparam int IW = 40;
   localparam int IF = 32;
   localparam int OW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [IW-1:0] in_data = '0;
   logic          out_valid;
   logic [OW-1:0] out_data;
   logic          range_flag;
   logic          cw_en = 1'b0;
   logic [3:0]    cw_seg = '0;
   logic [2:0]    cw_term = '0;
   logic [OW-1:0] cw_data = '0;

   always #2 clk = ~clk;

   lnx_approx_unit i_lnx_approx_unit (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_data    (in_data),
      .out_valid  (out_valid),
      .out_data   (out_data),
      .range_flag (range_flag),
      .cw_en      (cw_en),
      .cw_seg     (cw_seg),
      .cw_term    (cw_term),
      .cw_data    (cw_data)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;
   int cf [16][5];

   logic [OW-1:0] exp_data [$];
   int            exp_cyc  [$];
   string         exp_tag  [$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag,
                        input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
   endtask

   function automatic logic [127:0] decade(input int k);
      logic [127:0] v;
      v = 128'd1 << IF;
      for (int i = 0; i < k; i++) v = v / 128'd10;
      return v;
   endfunction

   function automatic int seg_of(input logic [IW-1:0] x);
      int e = -16;
      int ei = 8;
      int ii = 8;
      int idx = 0;
      for (int s = 0; s < 4; s++) begin
         if ({88'd0, x} < decade(-e)) e = e - ei;
         else begin
            e = e + ei;
            idx = idx + ii;
         end
         ei = ei / 2;
         ii = ii / 2;
      end
      return idx;
   endfunction

   function automatic logic [OW-1:0] model(input logic [IW-1:0] x);
      logic signed [127:0] a, xs, p;
      int sg;
      if (x == '0) return 32'h8000_0000;
      sg = seg_of(x);
      a  = '0;
      xs = $signed({88'd0, x});
      for (int t = 4; t >= 0; t--) begin
         p = a * xs;
         p = p >>> IF;
         p = p + cf[sg][t];
         if (p > 128'sh7FFF_FFFF) p = 128'sh7FFF_FFFF;
         if (p < -128'sh8000_0000) p = -128'sh8000_0000;
         a = p;
      end
      return a[OW-1:0];
   endfunction

   task automatic wr_coef(input int s, input int t, input int v);
      @(negedge clk);
      cw_en = 1'b1; cw_seg = 4'(s); cw_term = 3'(t); cw_data = v;
      @(negedge clk);
      cw_en = 1'b0;
      if (t < 5) cf[s][t] = v;
   endtask

   task automatic drain();
      while (exp_data.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   // driver: offers one operand, pushes its expected result
   task automatic convert(input logic [IW-1:0] x, input string tag, input int hold);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = x;
      exp_data.push_back(model(x));
      exp_cyc.push_back(cyc + 11);
      exp_tag.push_back(tag);
      @(negedge clk);
      check(in_ready == 1'b0, "R1 ready low after accept", 64'(in_ready), 64'd0);
      if (hold > 0) begin
         in_data = ~x;
         for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check(in_ready == 1'b0, "R1 busy ignores valid", 64'(in_ready), 64'd0);
         end
      end
      in_valid = 1'b0;
   endtask

   // monitor: pops expectations as results appear
   bit prev_ov = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            check(!prev_ov, "R6 single-cycle strobe", 64'(prev_ov), 64'd0);
            if (exp_data.size() == 0) begin
               check(1'b0, "R1 unexpected result", 64'(out_data), 64'd0);
            end else begin
               logic [OW-1:0] e;
               int ec;
               string tg;
               e  = exp_data.pop_front();
               ec = exp_cyc.pop_front();
               tg = exp_tag.pop_front();
               check(out_data == e, tg, 64'(out_data), 64'(e));
               check(cyc == ec, {"R6 latency ", tg}, 64'(cyc), 64'(ec));
            end
         end
         prev_ov = out_valid;
      end
   end

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int s = 0; s < 16; s++)
         for (int t = 0; t < 5; t++) cf[s][t] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b1, "R10 reset in_ready", 64'(in_ready), 64'd1);
      check(out_valid == 1'b0, "R10 reset out_valid", 64'(out_valid), 64'd0);
      check(range_flag == 1'b0, "R10 reset range_flag", 64'(range_flag), 64'd0);
      check(out_data == '0, "R10 reset out_data", 64'(out_data), 64'd0);

      // R10: empty bank gives zero for a nonzero operand
      convert(40'h1_0000_0000, "R10 cleared coefficients", 0);
      drain();

      // R9: load every coefficient with a distinct value
      for (int s = 0; s < 16; s++)
         for (int t = 0; t < 5; t++) begin
            int v = (s * 37 + t * 11 + 5) * 211;
            wr_coef(s, t, (t % 2 == 1) ? -v : v);
         end

      convert(40'd1, "R2 one LSB", 0);
      convert(40'h1_0000_0000, "R4 operand one", 0);
      convert(40'd42949672, "R3 equal to 10^-2 threshold", 0);
      convert(40'd42949671, "R3 just below 10^-2 threshold", 0);
      convert(40'd42, "R3 equal to 10^-8 threshold", 0);
      convert(40'd41, "R3 below 10^-8 threshold", 0);
      convert(40'h12_3456_7890, "R4 mid-range operand", 0);
      convert(40'h00_0010_0000, "R2 small operand", 0);
      convert(40'hFF_FFFF_FFFF, "R5 positive saturation", 0);
      drain();
      check(range_flag == 1'b0, "R8 flag clear for nonzero", 64'(range_flag), 64'd0);

      convert(40'd0, "R7 zero operand", 0);
      drain();
      check(range_flag == 1'b1, "R8 flag set by zero", 64'(range_flag), 64'd1);
      convert(40'h0_8000_0000, "R8 normal after zero", 0);
      drain();
      check(range_flag == 1'b1, "R8 flag sticky", 64'(range_flag), 64'd1);

      // R9: term codes 5..7 must not disturb any coefficient
      wr_coef(15, 5, 32'h1234_5678);
      wr_coef(14, 6, -32'h0765_4321);
      wr_coef(11, 7, 32'h0BAD_F00D);
      convert(40'd42949672, "R9 term 5 ignored", 0);
      convert(40'd42949671, "R9 term 6 ignored", 0);
      convert(40'd1, "R9 term 7 ignored", 0);
      drain();

      // R9 and R5: rewrite then force negative saturation
      wr_coef(11, 0, 32'h0003_0000);
      wr_coef(15, 4, -32'h0007_0000);
      convert(40'd1, "R9 rewritten c0", 0);
      convert(40'hFF_FFFF_FFFF, "R5 negative saturation", 0);

      // R1: valid held with other data during a conversion
      convert(40'h00_4000_0000, "R1 held valid single result", 5);

      // back-to-back stream
      for (int k = 0; k < 6; k++)
         convert(40'(64'h0000_0100_0000 << (2 * k)) + 40'(k), "R2 stream operand", 0);
      drain();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule